// File: doc/BRIEF.md
# Iterative Reduced-Width TEA Encryption Engine

This block encrypts one 16-bit block under a 32-bit key with a scaled-down form of the Tiny Encryption Algorithm. Each half of the block is 8 bits wide and each subkey is one byte. All arithmetic wraps modulo 256. A single 8-bit adder is shared across the whole computation. A small controller steps it through nine micro-operations per iteration and runs eight iterations per block.

A client presents the plaintext and the key and pulses `start` while the engine is idle. About seventy cycles later the engine raises `done` for one cycle. The ciphertext then sits on `result` and stays there until the next accepted start. While a block is in flight, further start pulses have no effect.

Top module: `tea_mini_enc`

## Requirements
- R1: After reset, `done` is 0 and `result` is 16'h0000.
- R2: One iteration first adds the constant 8'hA0 to a running sum. It then adds ((v1 shifted left 4) + k0) XOR (v1 + sum) XOR ((v1 shifted right 5) + k1) to v0, with every operation taken modulo 256. Field positions are fixed: v0 = `blk_in[15:8]`, v1 = `blk_in[7:0]`, k0 = `key_in[7:0]`, k1 = `key_in[15:8]`, k2 = `key_in[23:16]` and k3 = `key_in[31:24]`.
- R3: After v0 is updated, v1 gains ((v0 shifted left 4) + k2) XOR (v0 + sum) XOR ((v0 shifted right 5) + k3), using the new v0.
- R4: Both shifts are logical and fill with zeros. The left shift keeps bits [3:0] as the new [7:4]; the right shift moves bits [7:5] to [2:0].
- R5: A block receives exactly 8 iterations. The running sum starts from zero on every accepted start, so repeated runs on the same inputs give the same ciphertext.
- R6: `done` is a single-cycle pulse. It is first high in the cycle after the 72nd rising edge that follows the edge accepting `start`.
- R7: `result` holds {v0, v1} (v0 in bits [15:8]) and does not change from the `done` pulse until the next accepted start, whatever the other inputs do.
- R8: A start pulse that arrives while a block is in progress is ignored. The running block completes with its original inputs and its original timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a block; sampled only while idle |
| blk_in | input | 16 | Plaintext, v0 in [15:8], v1 in [7:0] |
| key_in | input | 32 | Key, k0 in [7:0] up to k3 in [31:24] |
| done | output | 1 | One-cycle pulse when the ciphertext is ready |
| result | output | 16 | Ciphertext {v0, v1} |

## Verification
The embedded assertions check the protocol properties on every cycle:
- `done` never lasts two cycles and only follows a busy cycle.
- The key register and the running sum change only in their own load or step cycles.
- A start that arrives while busy never produces a load.
- The result is frozen while idle.

The arithmetic cannot be shown by a property. This covers the formula, the shift fill, the use of the fresh v0 and the exact count of iterations. The bench shows these by comparing the ciphertext against an arithmetic model across hundreds of block and key patterns. It also runs directed cases for the 72-cycle latency, repeated runs and mid-run start pulses.

// File: rtl/tea_mini_pkg.sv
package tea_mini_pkg;
  // Micro-step order inside one iteration; the sum step must come first,
  // and the v0 group must finish before the v1 group begins.
  typedef enum logic [3:0] {
    ST_SUM = 4'd0,
    ST_A0  = 4'd1,
    ST_B0  = 4'd2,
    ST_C0  = 4'd3,
    ST_D0  = 4'd4,
    ST_A1  = 4'd5,
    ST_B1  = 4'd6,
    ST_C1  = 4'd7,
    ST_D1  = 4'd8
  } step_e;
endpackage

// File: rtl/tea_mini_ctrl.sv
module tea_mini_ctrl
  import tea_mini_pkg::*;
#(
  parameter int ROUNDS = 8
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  output logic  busy,
  output logic  load,
  output step_e step,
  output logic  done
);
  localparam int IW = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;
  localparam logic [IW-1:0] LAST_ITER = IW'(ROUNDS - 1);

  logic          busy_q, busy_n;
  logic          done_q, done_n;
  step_e         step_q, step_n;
  logic [IW-1:0] iter_q, iter_n;

  always_comb begin
    load   = start && !busy_q;
    busy_n = busy_q;
    step_n = step_q;
    iter_n = iter_q;
    done_n = 1'b0;
    if (load) begin
      busy_n = 1'b1;
      step_n = ST_SUM;
      iter_n = '0;
    end else if (busy_q) begin
      if (step_q == ST_D1) begin
        step_n = ST_SUM;
        if (iter_q == LAST_ITER) begin
          busy_n = 1'b0;
          done_n = 1'b1;
        end else begin
          iter_n = iter_q + 1'b1;
        end
      end else begin
        step_n = step_e'(step_q + 4'd1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      step_q <= ST_SUM;
      iter_q <= '0;
    end else begin
      busy_q <= busy_n;
      done_q <= done_n;
      step_q <= step_n;
      iter_q <= iter_n;
    end
  end

  assign busy = busy_q;
  assign step = step_q;
  assign done = done_q;

  // R6: the completion flag lasts a single cycle
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R6: completion only follows a cycle of work
  a_r6_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(busy_q));
endmodule

// File: rtl/tea_mini_datapath.sv
module tea_mini_datapath
  import tea_mini_pkg::*;
#(
  parameter int          W     = 8,
  parameter int          SHL   = 4,
  parameter int          SHR   = 5,
  parameter logic [W-1:0] DELTA = 8'hA0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           busy,
  input  step_e          step,
  input  logic [2*W-1:0] blk_in,
  input  logic [4*W-1:0] key_in,
  output logic [W-1:0]   v0,
  output logic [W-1:0]   v1
);
  logic [W-1:0]      v0_q, v1_q, sum_q, acc_q;
  logic [W-1:0]      v0_n, v1_n, sum_n, acc_n;
  logic [3:0][W-1:0] key_q;
  logic [W-1:0]      src, dst, k_lo, k_hi, op_a, op_b, add_r;
  logic              second_half;

  // Operand selection for the single shared adder
  always_comb begin
    second_half = (step >= ST_A1);
    src  = second_half ? v0_q : v1_q;
    dst  = second_half ? v1_q : v0_q;
    k_lo = second_half ? key_q[2] : key_q[0];
    k_hi = second_half ? key_q[3] : key_q[1];
    unique case (step)
      ST_SUM:       begin op_a = DELTA;                       op_b = sum_q; end
      ST_A0, ST_A1: begin op_a = {src[W-SHL-1:0], {SHL{1'b0}}}; op_b = k_lo; end
      ST_B0, ST_B1: begin op_a = src;                         op_b = sum_q; end
      ST_C0, ST_C1: begin op_a = {{SHR{1'b0}}, src[W-1:SHR]};   op_b = k_hi; end
      default:      begin op_a = acc_q;                       op_b = dst;   end
    endcase
    add_r = op_a + op_b;
  end

  // Next values of the working registers
  always_comb begin
    v0_n  = v0_q;
    v1_n  = v1_q;
    sum_n = sum_q;
    acc_n = acc_q;
    unique case (step)
      ST_SUM:       sum_n = add_r;
      ST_A0, ST_A1: acc_n = add_r;
      ST_D0:        v0_n  = add_r;
      ST_D1:        v1_n  = add_r;
      default:      acc_n = acc_q ^ add_r;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v0_q  <= '0;
      v1_q  <= '0;
      sum_q <= '0;
      acc_q <= '0;
      key_q <= '0;
    end else if (load) begin
      v0_q  <= blk_in[2*W-1:W];
      v1_q  <= blk_in[W-1:0];
      sum_q <= '0;
      acc_q <= '0;
      key_q <= key_in;
    end else if (busy) begin
      v0_q  <= v0_n;
      v1_q  <= v1_n;
      sum_q <= sum_n;
      acc_q <= acc_n;
    end
  end

  assign v0 = v0_q;
  assign v1 = v1_q;

  // R5: the running sum only advances in its own micro-step
  a_r5_sum_only_on_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !(busy && step == ST_SUM)) |=> $stable(sum_q));
  // R8: the key is captured only by an accepted start
  a_r8_key_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(key_q));
endmodule

// File: rtl/tea_mini_enc.sv
module tea_mini_enc
  import tea_mini_pkg::*;
#(
  parameter int W      = 8,
  parameter int ROUNDS = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [2*W-1:0] blk_in,
  input  logic [4*W-1:0] key_in,
  output logic           done,
  output logic [2*W-1:0] result
);
  logic         busy_w, load_w;
  step_e        step_w;
  logic [W-1:0] v0_w, v1_w;

  tea_mini_ctrl #(.ROUNDS(ROUNDS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .busy(busy_w), .load(load_w), .step(step_w), .done(done)
  );

  tea_mini_datapath #(.W(W)) u_dp (
    .clk(clk), .rst_n(rst_n), .load(load_w), .busy(busy_w), .step(step_w),
    .blk_in(blk_in), .key_in(key_in), .v0(v0_w), .v1(v1_w)
  );

  assign result = {v0_w, v1_w};

  // R8: a start during work never triggers a reload
  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_w && start) |-> !load_w);
  // R7: while idle and not restarted, the output is frozen
  a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_w && !start) |=> $stable(result));
endmodule

// File: tb/tb_tea_mini_enc.sv
`timescale 1ns/1ps
module tb_tea_mini_enc;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [15:0] blk_in;
  logic [31:0] key_in;
  logic        done;
  logic [15:0] result;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  tea_mini_enc dut (
    .clk(clk), .rst_n(rst_n), .start(start), .blk_in(blk_in),
    .key_in(key_in), .done(done), .result(result)
  );

  function automatic logic [15:0] ref_enc(input logic [15:0] b, input logic [31:0] k);
    logic [7:0] v0, v1, s, k0, k1, k2, k3;
    v0 = b[15:8]; v1 = b[7:0];
    k0 = k[7:0]; k1 = k[15:8]; k2 = k[23:16]; k3 = k[31:24];
    s = 8'h00;
    for (int i = 0; i < 8; i++) begin
      s  = s + 8'hA0;
      v0 = v0 + ((((v1 << 4) & 8'hF0) + k0) ^ (v1 + s) ^ ((v1 >> 5) + k1));
      v1 = v1 + ((((v0 << 4) & 8'hF0) + k2) ^ (v0 + s) ^ ((v0 >> 5) + k3));
    end
    return {v0, v1};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Start a block, wait for done; returns latency and ciphertext
  task automatic run(input logic [15:0] b, input logic [31:0] k,
                     output logic [15:0] res, output int lat);
    @(negedge clk);
    blk_in = b; key_in = k; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    res = result;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] r, r2, b;
    logic [31:0] k;
    int lat;
    rst_n = 1'b0; start = 1'b0; blk_in = '0; key_in = '0;
    repeat (3) @(negedge clk);
    check("R1 done", {31'd0, done}, 32'd0);
    check("R1 result", {16'd0, result}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle result", {16'd0, result}, 32'd0);

    // R6 latency and pulse width, R2/R3 on the all-zero block
    run(16'h0000, 32'h0, r, lat);
    check("R6 latency", lat, 72);
    check("R2 R3 zero", {16'd0, r}, {16'd0, ref_enc(16'h0, 32'h0)});
    @(negedge clk);
    check("R6 single pulse", {31'd0, done}, 32'd0);

    // R4 shift fill: all-ones block and key
    run(16'hFFFF, 32'hFFFF_FFFF, r, lat);
    check("R4 ones", {16'd0, r}, {16'd0, ref_enc(16'hFFFF, 32'hFFFF_FFFF)});

    // R5 repeated runs on the same inputs match
    run(16'h3C81, 32'h0123_4567, r, lat);
    run(16'h3C81, 32'h0123_4567, r2, lat);
    check("R5 repeat", {16'd0, r2}, {16'd0, r});
    check("R5 value", {16'd0, r2}, {16'd0, ref_enc(16'h3C81, 32'h0123_4567)});

    // R7 hold after done while inputs wander
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      blk_in = 16'(i * 97); key_in = 32'(i * 32'h1357_9BDF);
    end
    check("R7 hold", {16'd0, result}, {16'd0, r2});

    // R8 start mid-run is ignored
    @(negedge clk);
    blk_in = 16'hA55A; key_in = 32'hDEAD_BEEF; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    repeat (9) begin @(negedge clk); lat++; end
    blk_in = 16'h1234; key_in = 32'h0F0F_0F0F; start = 1'b1;
    @(negedge clk); lat++;
    start = 1'b0;
    while (!done && lat < 200) begin @(negedge clk); lat++; end
    check("R8 latency", lat, 72);
    check("R8 result", {16'd0, result}, {16'd0, ref_enc(16'hA55A, 32'hDEAD_BEEF)});

    // Sweep: R2 R3 R4 R5 across every v0 byte and many v1/key patterns
    for (int i = 0; i < 512; i++) begin
      b = {i[7:0], 8'(i[7:0] * 8'd37) ^ {7'd0, i[8]}};
      k = {8'(i * 3), 8'(i ^ 8'hC3), 8'(i * 11 + 5), 8'(255 - i)};
      run(b, k, r, lat);
      check("R2 R3 R4 sweep", {16'd0, r}, {16'd0, ref_enc(b, k)});
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule